// File: doc/BRIEF.md
# Pending Block-Read Snoop Tracker

This block sits beside a cache controller and follows the single block read that the cache has outstanding on the shared bus. When the cache puts out its read request, the tracker keeps the requested address. While the reply is pending it looks at every packet that passes on the bus and keeps two sticky facts about that address. The first is whether some other cache is also touching the block, so the block must be marked shared. The second is whether a write to the block has been committed, so the data about to come back can no longer be trusted.

When the matching reply arrives, the tracker reports one of two results. If the data is still good, it gives a one-cycle install strobe with the shared value to store alongside the fetched block: the reply's own shared indication merged with whatever was gathered from snooping. If the data is stale, it gives a one-cycle reissue strobe instead. The tracker then stays armed on the same address with its flags cleared, so the repeated request starts clean.

Top module: `rb_snoop_tracker`

## Requirements
- R1: After reset, `armed`, `install_vld`, `install_shared` and `reissue` are all 0.
- R2: A cycle with `issue_vld` high arms the tracker and stores `issue_addr`. From the next cycle `armed` reads 1. A `rply_done` that arrives while the tracker is not armed has no effect on any output.
- R3: A snooped address matches the stored one when the two differ only in the word-within-block bits, which are the low 3 address bits for an 8-word block. A difference in any higher bit is not a match.
- R4: A valid matching snoop packet with command code 0 (block read), 1 (block write), 2 (single write) or 3 (conditional single write) sets the shared accumulator. This holds whether `snp_rply` is 0 (request) or 1 (reply). The accumulator stays set until the tracker is cleared.
- R5: Command code 4 (flush) and every code from 5 to 15 set neither the shared accumulator nor the stale flag.
- R6: The stale flag is set only by a matching single-write reply (code 2 with `snp_rply`=1), a matching conditional-single-write reply (code 3 with `snp_rply`=1) or a matching block-write request (code 1 with `snp_rply`=0).
- R7: A snoop packet whose `snp_id` equals `my_id` never sets either flag.
- R8: When an accepted `rply_done` finds the tracker not stale, `install_vld` is 1 for exactly the following cycle. In that cycle `install_shared` equals `rply_shared` OR the shared accumulator, and `armed` returns to 0.
- R9: When an accepted `rply_done` finds the tracker stale, `reissue` is 1 for exactly the following cycle and `install_vld` stays 0. `armed` stays 1, and both flags are cleared, so a later clean reply installs with `install_shared` equal to `rply_shared` alone.
- R10: A snoop that arrives in the same cycle as `rply_done` counts toward that reply, for both the shared accumulator and the stale decision.
- R11: `issue_vld` has priority. In its cycle, snoops and `rply_done` are ignored, the new address replaces the old one and both flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| my_id | input | ID_W | Device id of this cache |
| issue_vld | input | 1 | This cache puts out a block read request this cycle |
| issue_addr | input | ADDR_W | Word address of that request |
| snp_vld | input | 1 | A bus packet header is present this cycle |
| snp_cmd | input | 4 | Command code of the snooped packet |
| snp_rply | input | 1 | 1 for a reply packet, 0 for a request |
| snp_id | input | ID_W | Device id carried by the snooped packet |
| snp_addr | input | ADDR_W | Address carried by the snooped packet |
| rply_done | input | 1 | The reply to the tracked read has arrived |
| rply_shared | input | 1 | Shared indication carried by that reply |
| armed | output | 1 | A read is being tracked |
| install_vld | output | 1 | One-cycle strobe: install the fetched block |
| install_shared | output | 1 | Shared bit to install with the block |
| reissue | output | 1 | One-cycle strobe: send the read again |

## Verification
A snooped packet and the arrival of the reply can fall in the same cycle. The tracker then has to fold the snoop into the decision it makes on that same edge, rather than applying it to an attempt that has already finished. The bench provokes this by repeating its full sweep over every command code, both phases, own/foreign id and three address relations, once with the snoop one cycle before the reply and once with the two together. In each case it judges whether install or reissue fires and which shared value appears. After every reissue it sends a clean reply to confirm that no flag from the earlier attempt has leaked into the new one.

// File: rtl/rbst_pkg.sv
package rbst_pkg;

  // Bus command codes; the numeric values are fixed by the bus.
  typedef enum logic [3:0] {
    CMD_RD_BLK  = 4'h0,
    CMD_WR_BLK  = 4'h1,
    CMD_WR_ONE  = 4'h2,
    CMD_WR_COND = 4'h3,
    CMD_FLUSH   = 4'h4
  } bus_cmd_e;

  typedef enum logic [1:0] {
    OUT_NONE    = 2'd0,
    OUT_INSTALL = 2'd1,
    OUT_REISSUE = 2'd2
  } rply_out_e;

  // Commands whose traffic proves another holder of the block.
  function automatic logic cmd_shares(input logic [3:0] cmd);
    return (cmd == CMD_RD_BLK) || (cmd == CMD_WR_BLK) ||
           (cmd == CMD_WR_ONE) || (cmd == CMD_WR_COND);
  endfunction

  // Packets that commit a write to memory state.
  function automatic logic cmd_stales(input logic [3:0] cmd, input logic is_rply);
    return ((cmd == CMD_WR_ONE)  &&  is_rply) ||
           ((cmd == CMD_WR_COND) &&  is_rply) ||
           ((cmd == CMD_WR_BLK)  && !is_rply);
  endfunction

endpackage

// File: rtl/rbst_match.sv
module rbst_match #(
  parameter int ADDR_W    = 16,
  parameter int ID_W      = 4,
  parameter int BLK_WORDS = 8
) (
  input  logic              armed,
  input  logic              blocked,
  input  logic [ADDR_W-1:0] trk_addr,
  input  logic [ID_W-1:0]   my_id,
  input  logic              snp_vld,
  input  logic [3:0]        snp_cmd,
  input  logic              snp_rply,
  input  logic [ID_W-1:0]   snp_id,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              hit_share,
  output logic              hit_stale
);
  import rbst_pkg::*;

  localparam int OFS_W = $clog2(BLK_WORDS);
  localparam logic [ADDR_W-1:0] BLK_MASK = {{(ADDR_W-OFS_W){1'b1}}, {OFS_W{1'b0}}};

  logic [ADDR_W-1:0] diff;
  logic              addr_eq;
  logic              foreign;
  logic              live;

  always_comb begin
    diff      = trk_addr ^ snp_addr;
    addr_eq   = ~|(diff & BLK_MASK);
    foreign   = (snp_id != my_id);
    live      = armed && !blocked && snp_vld && addr_eq && foreign;
    hit_share = live && cmd_shares(snp_cmd);
    hit_stale = live && cmd_stales(snp_cmd, snp_rply);
  end

endmodule

// File: rtl/rbst_flags.sv
module rbst_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set_share,
  input  logic set_stale,
  output logic share_q,
  output logic stale_q
);

  logic en;
  logic share_d;
  logic stale_d;

  always_comb begin
    en      = clr || set_share || set_stale;
    share_d = clr ? 1'b0 : (share_q || set_share);
    stale_d = clr ? 1'b0 : (stale_q || set_stale);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      share_q <= 1'b0;
      stale_q <= 1'b0;
    end else if (en) begin
      share_q <= share_d;
      stale_q <= stale_d;
    end
  end

  // R6
  stale_implies_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stale_q |-> share_q);

  // R11
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!share_q && !stale_q));

endmodule

// File: rtl/rb_snoop_tracker.sv
module rb_snoop_tracker #(
  parameter int ADDR_W    = 16,
  parameter int ID_W      = 4,
  parameter int BLK_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   my_id,
  input  logic              issue_vld,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic              snp_vld,
  input  logic [3:0]        snp_cmd,
  input  logic              snp_rply,
  input  logic [ID_W-1:0]   snp_id,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              rply_done,
  input  logic              rply_shared,
  output logic              armed,
  output logic              install_vld,
  output logic              install_shared,
  output logic              reissue
);
  import rbst_pkg::*;

  logic              armed_q, armed_d;
  logic [ADDR_W-1:0] addr_q;
  logic              addr_en;
  logic              hit_share, hit_stale;
  logic              share_q, stale_q;
  logic              take;
  logic              flag_clr;
  rply_out_e         out_d;
  logic              inst_shr_d;
  logic              inst_q, inst_shr_q, reis_q;

  rbst_match #(.ADDR_W(ADDR_W), .ID_W(ID_W), .BLK_WORDS(BLK_WORDS)) u_match (
    .armed     (armed_q),
    .blocked   (issue_vld),
    .trk_addr  (addr_q),
    .my_id     (my_id),
    .snp_vld   (snp_vld),
    .snp_cmd   (snp_cmd),
    .snp_rply  (snp_rply),
    .snp_id    (snp_id),
    .snp_addr  (snp_addr),
    .hit_share (hit_share),
    .hit_stale (hit_stale)
  );

  rbst_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (flag_clr),
    .set_share (hit_share),
    .set_stale (hit_stale),
    .share_q   (share_q),
    .stale_q   (stale_q)
  );

  // Next-state logic.
  always_comb begin
    take       = rply_done && armed_q && !issue_vld;
    flag_clr   = issue_vld || take;
    addr_en    = issue_vld;
    armed_d    = armed_q;
    out_d      = OUT_NONE;
    inst_shr_d = 1'b0;
    if (issue_vld) begin
      armed_d = 1'b1;
    end else if (take) begin
      if (stale_q || hit_stale) begin
        out_d = OUT_REISSUE;
      end else begin
        out_d      = OUT_INSTALL;
        inst_shr_d = rply_shared || share_q || hit_share;
        armed_d    = 1'b0;
      end
    end
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= issue_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      inst_q     <= 1'b0;
      inst_shr_q <= 1'b0;
      reis_q     <= 1'b0;
    end else begin
      armed_q    <= armed_d;
      inst_q     <= (out_d == OUT_INSTALL);
      inst_shr_q <= inst_shr_d;
      reis_q     <= (out_d == OUT_REISSUE);
    end
  end

  assign armed          = armed_q;
  assign install_vld    = inst_q;
  assign install_shared = inst_shr_q;
  assign reissue        = reis_q;

  // R8
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(install_vld && reissue));

  // R2
  result_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (install_vld || reissue) |-> $past(armed_q));

  // R8
  install_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    install_vld |-> !armed);

  // R9
  reissue_keeps_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reissue |-> armed);

  // R7
  own_id_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_vld && snp_id == my_id && !share_q) |=> !share_q || $past(issue_vld));

  // R1
  shared_only_with_install_chk: assert property (@(posedge clk) disable iff (!rst_n)
    install_shared |-> install_vld);

endmodule

// File: tb/test_rb_snoop_tracker.sv
module test_rb_snoop_tracker;

  localparam int ADDR_W = 16;
  localparam int ID_W   = 4;
  localparam logic [ID_W-1:0]   MY = 4'h6;
  localparam logic [ADDR_W-1:0] A  = 16'h5A38;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              issue_vld;
  logic [ADDR_W-1:0] issue_addr;
  logic              snp_vld;
  logic [3:0]        snp_cmd;
  logic              snp_rply;
  logic [ID_W-1:0]   snp_id;
  logic [ADDR_W-1:0] snp_addr;
  logic              rply_done;
  logic              rply_shared;
  logic              armed, install_vld, install_shared, reissue;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rb_snoop_tracker #(.ADDR_W(ADDR_W), .ID_W(ID_W), .BLK_WORDS(8)) i_rb_snoop_tracker (
    .clk(clk), .rst_n(rst_n), .my_id(MY),
    .issue_vld(issue_vld), .issue_addr(issue_addr),
    .snp_vld(snp_vld), .snp_cmd(snp_cmd), .snp_rply(snp_rply),
    .snp_id(snp_id), .snp_addr(snp_addr),
    .rply_done(rply_done), .rply_shared(rply_shared),
    .armed(armed), .install_vld(install_vld),
    .install_shared(install_shared), .reissue(reissue)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // Vector order: {armed, install_vld, install_shared, reissue}
  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%b exp=%b", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {armed, install_vld, install_shared, reissue};
  endfunction

  task automatic idle();
    issue_vld = 0; snp_vld = 0; rply_done = 0; rply_shared = 0;
    snp_cmd = 0; snp_rply = 0; snp_id = 0; snp_addr = 0;
  endtask

  task automatic snoop(input logic [3:0] c, input logic p, input logic own, input int mk);
    snp_vld  = 1;
    snp_cmd  = c;
    snp_rply = p;
    snp_id   = own ? MY : (MY ^ 4'h1);
    snp_addr = (mk == 0) ? A : (mk == 1) ? (A ^ 16'h0005) : (A ^ 16'h0100);
  endtask

  task automatic scenario(input int c, input int p, input int own, input int mk, input int same);
    logic rs, eff, sh, st;
    string tag;
    rs  = logic'(c[0] ^ p[0]);
    eff = (mk != 2) && (own == 0);
    // R4: codes 0..3 share; R6: stale only on 2/3 reply, 1 request
    sh  = eff && (c <= 3);
    st  = eff && ((c == 2 && p == 1) || (c == 3 && p == 1) || (c == 1 && p == 0));
    if (same != 0)      tag = "R10";
    else if (mk == 1)   tag = "R3";
    else if (mk == 2)   tag = "R3_miss";
    else if (own != 0)  tag = "R7";
    else if (c >= 4)    tag = "R5";
    else if (st)        tag = "R6";
    else                tag = "R4";
    @(negedge clk); idle(); issue_vld = 1; issue_addr = A;
    @(negedge clk); idle();
    if (same == 0) begin
      snoop(4'(c), p[0], own[0], mk);
      @(negedge clk); idle();
    end else begin
      snoop(4'(c), p[0], own[0], mk);
    end
    rply_done = 1; rply_shared = rs;
    @(negedge clk); idle();
    // R8 install path / R9 reissue path
    chk(tag, outs(), st ? 4'b1001 : {1'b0, 1'b1, rs | sh, 1'b0});
    if (st) begin
      rply_done = 1; rply_shared = 0;
      @(negedge clk); idle();
      chk("R9_clear", outs(), 4'b0100);
    end
  endtask

  initial begin
    idle();
    issue_addr = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1", outs(), 4'b0000);
    rst_n = 1;
    @(negedge clk);
    chk("R1", outs(), 4'b0000);

    // R2: reply while idle does nothing
    rply_done = 1; rply_shared = 1;
    @(negedge clk); idle();
    chk("R2_idle", outs(), 4'b0000);
    @(negedge clk);
    chk("R2_idle", outs(), 4'b0000);

    // R2: issue arms
    issue_vld = 1; issue_addr = A;
    @(negedge clk); idle();
    chk("R2", outs(), 4'b1000);

    // R11: matching share on old address, then reissue elsewhere clears it
    snoop(4'h0, 1'b0, 1'b0, 0);
    @(negedge clk); idle();
    issue_vld = 1; issue_addr = A ^ 16'h0200;
    snoop(4'h1, 1'b0, 1'b0, 0);
    rply_done = 1;
    @(negedge clk); idle();
    chk("R11", outs(), 4'b1000);
    rply_done = 1; rply_shared = 0;
    @(negedge clk); idle();
    chk("R11", outs(), 4'b0100);

    // Full sweep, separate-cycle and same-cycle snoops
    for (int same = 0; same < 2; same++)
      for (int c = 0; c < 16; c++)
        for (int p = 0; p < 2; p++)
          for (int own = 0; own < 2; own++)
            for (int mk = 0; mk < 3; mk++)
              scenario(c, p, own, mk, same);

    // R4: accumulator sticky across a later foreign non-sharing packet
    @(negedge clk); issue_vld = 1; issue_addr = A;
    @(negedge clk); idle(); snoop(4'h2, 1'b0, 1'b0, 0);
    @(negedge clk); idle(); snoop(4'h4, 1'b0, 1'b0, 0);
    @(negedge clk); idle(); rply_done = 1; rply_shared = 0;
    @(negedge clk); idle();
    chk("R4_sticky", outs(), 4'b0110);
    @(negedge clk);
    chk("R8_pulse", outs(), 4'b0000);

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule